// File: doc/BRIEF.md
# Three-Phase Dead-Band PWM Generator

This block turns one shared carrier count into six gate-drive signals for a three-phase bridge. Each of three phases compares its own threshold against the carrier and forms a raw switching signal. A dead-band stage splits that signal into an upper and a lower switch command. On every raw edge the switch that is turning off drops at once, and the switch that is turning on waits for a programmable number of clocks. This keeps the two switches of a leg from ever conducting together.

A per-output two-bit action code maps each switch command onto its pin. The code can pass the command through with either polarity, or it can hold the pin at a fixed level. Codes are written into a shadow register at any time. They reach the outputs only when the carrier passes through zero, so a polarity change never takes effect partway through a carrier period. A global enable parks every pin at its inactive level.

Top module: `dbpwm_3ph`

## Requirements
- R1: For phase p (threshold `cmp_i[16p+15:16p]`), the upper switch command is on while threshold > `cnt_i` and the lower command is on otherwise (an equal value counts as lower). Pin `pwm_o[2p]` carries the upper command and `pwm_o[2p+1]` carries the lower one.
- R2: Given a `cnt_i`/`cmp_i` value sampled on rising edge k, the command that turns off changes its pin at edge k+1. With `dead_i` = D, the command that turns on changes its pin at edge k+1+D.
- R3: The dead time spans 0 to 255 clocks. With D = 0 both pins of a pair change on the same edge. With D = 255 the turn-on comes 255 clocks after the turn-off.
- R4: A raw pulse lasting fewer clocks than D leaves both commands of that pair off for the whole pulse.
- R5: Output n takes its action code from bits [2n+1:2n]. Code 00 holds the pin low, 01 drives the pin low when the command is on (active low), 10 drives it high when on (active high), and 11 holds the pin high.
- R6: A write with `act_we_i` stores `act_wdata_i` only in the shadow register, and the outputs keep the old codes. The active codes take the shadow value at a clock edge where `cnt_i` is zero.
- R7: After reset, both registers hold 01 for the even (upper) outputs and 10 for the odd (lower) outputs. During reset `pwm_o` is 6'b010101.
- R8: When `en_i` is low at a rising edge, every pin takes its inactive level at that edge: 1 for code 01 and 0 for every other code. When `en_i` returns high, the pins follow their commands again on the next edge.
- R9: The three phases are independent: each pair follows only its own threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global output enable |
| cnt_i | input | 16 | Shared carrier count |
| cmp_i | input | 48 | Three phase thresholds, phase 0 in the low bits |
| dead_i | input | 8 | Dead time in clocks |
| act_we_i | input | 1 | Shadow action register write strobe |
| act_wdata_i | input | 12 | Shadow action codes, 2 bits per output |
| pwm_o | output | 6 | Gate pins, upper/lower pair per phase |

## Verification
The bench moves one threshold across the carrier and times each pin edge against the dead time at 0, 3 and 255 clocks. A design that delayed the turn-off, or counted the delay one clock off, would show the wrong pair value on a specific edge. A pulse shorter than the dead time must leave both switches off, which catches a dead-band counter that runs across a raw edge instead of restarting there. A shadow write is made mid-period to show that pins keep the old codes until a carrier zero, which exposes a design that loads the codes straight through. The disable test uses mixed codes to show that an active-low output parks high while forced outputs park low.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    ACT_FORCE_LO = 2'b00,
    ACT_LOW      = 2'b01,
    ACT_HIGH     = 2'b10,
    ACT_FORCE_HI = 2'b11
  } act_code_e;
endpackage

// File: rtl/dbpwm_cmp.sv
module dbpwm_cmp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             raw_o
);
  // equal counts as lower-switch region
  assign raw_o = thr_i > cnt_i;
endmodule

// File: rtl/dbpwm_dead.sv
module dbpwm_dead #(
  parameter int DEAD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              up_on_o,
  output logic              lo_on_o
);
  logic              raw_q;
  logic [DEAD_W-1:0] run_q;
  logic              settled;

  // run_q: clocks since last raw edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      run_q <= '1;
    end else begin
      raw_q <= raw_i;
      if (raw_i != raw_q)   run_q <= '0;
      else if (run_q != '1) run_q <= run_q + 1'b1;
    end
  end

  assign settled = run_q >= dead_i;
  assign up_on_o = raw_q & settled;
  assign lo_on_o = ~raw_q & settled;
endmodule

// File: rtl/dbpwm_act.sv
module dbpwm_act #(
  parameter int        W     = 12,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_V;
      act_q    <= RST_V;
    end else begin
      if (we_i)   shadow_q <= wdata_i;
      if (load_i) act_q    <= shadow_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/dbpwm_out.sv
module dbpwm_out
  import dbpwm_pkg::*;
#(
  parameter logic RST_LVL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              on_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pin_o
);
  logic drive;
  logic idle;
  logic pin_q;

  always_comb begin
    case (code_i)
      ACT_FORCE_LO: drive = 1'b0;
      ACT_LOW:      drive = ~on_i;
      ACT_HIGH:     drive = on_i;
      default:      drive = 1'b1;
    endcase
    idle = (code_i == ACT_LOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= RST_LVL;
    else         pin_q <= en_i ? drive : idle;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/dbpwm_3ph.sv
module dbpwm_3ph
  import dbpwm_pkg::*;
#(
  parameter int N_PH   = 3,
  parameter int CNT_W  = 16,
  parameter int DEAD_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [N_PH*CNT_W-1:0]    cmp_i,
  input  logic [DEAD_W-1:0]        dead_i,
  input  logic                     act_we_i,
  input  logic [2*N_PH*CODE_W-1:0] act_wdata_i,
  output logic [2*N_PH-1:0]        pwm_o
);
  localparam int N_OUT  = 2 * N_PH;
  localparam int ACT_W  = N_OUT * CODE_W;

  function automatic logic [ACT_W-1:0] dflt_codes();
    logic [ACT_W-1:0] v;
    for (int n = 0; n < N_OUT; n++)
      v[n*CODE_W +: CODE_W] = (n % 2 == 0) ? ACT_LOW : ACT_HIGH;
    return v;
  endfunction

  localparam logic [ACT_W-1:0] ACT_RST = dflt_codes();

  logic [N_PH-1:0]  raw;
  logic [N_PH-1:0]  on_up;
  logic [N_PH-1:0]  on_lo;
  logic [N_OUT-1:0] on_cmd;
  logic [ACT_W-1:0] act_q;
  logic             at_zero;

  assign at_zero = (cnt_i == '0);

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    dbpwm_cmp #(.CNT_W(CNT_W)) u_cmp (
      .cnt_i (cnt_i),
      .thr_i (cmp_i[p*CNT_W +: CNT_W]),
      .raw_o (raw[p])
    );

    dbpwm_dead #(.DEAD_W(DEAD_W)) u_dead (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (raw[p]),
      .dead_i  (dead_i),
      .up_on_o (on_up[p]),
      .lo_on_o (on_lo[p])
    );

    assign on_cmd[2*p]   = on_up[p];
    assign on_cmd[2*p+1] = on_lo[p];
  end

  dbpwm_act #(.W(ACT_W), .RST_V(ACT_RST)) u_act (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (act_we_i),
    .wdata_i (act_wdata_i),
    .load_i  (at_zero),
    .act_o   (act_q)
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    dbpwm_out #(.RST_LVL(n % 2 == 0)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .on_i   (on_cmd[n]),
      .code_i (act_q[n*CODE_W +: CODE_W]),
      .pin_o  (pwm_o[n])
    );
  end
endmodule

// File: rtl/dbpwm_3ph_chk.sv
module dbpwm_3ph_chk #(
  parameter int N_PH   = 3,
  parameter int CNT_W  = 16,
  parameter int DEAD_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic [CNT_W-1:0]      cnt_i,
  input logic [DEAD_W-1:0]     dead_i,
  input logic [N_PH-1:0]       on_up,
  input logic [N_PH-1:0]       on_lo,
  input logic [4*N_PH-1:0]     act_q,
  input logic [2*N_PH-1:0]     pwm_o
);
  logic [2*N_PH-1:0] idle_v;

  always_comb
    for (int n = 0; n < 2*N_PH; n++)
      idle_v[n] = (act_q[2*n +: 2] == 2'b01);

  // R1
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_up & on_lo) == '0);

  // R8
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pwm_o == $past(idle_v));

  // R6
  shadow_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(cnt_i) == '0);

  for (genvar p = 0; p < N_PH; p++) begin : g_gap
    // R2
    up_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dead_i != '0) && $rose(on_up[p]) |-> !$past(on_lo[p]));
    // R2
    lo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dead_i != '0) && $rose(on_lo[p]) |-> !$past(on_up[p]));
  end
endmodule

bind dbpwm_3ph dbpwm_3ph_chk #(.N_PH(N_PH), .CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .cnt_i  (cnt_i),
  .dead_i (dead_i),
  .on_up  (on_up),
  .on_lo  (on_lo),
  .act_q  (act_q),
  .pwm_o  (pwm_o)
);

// File: tb/dbpwm_3ph_tb.sv
module dbpwm_3ph_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [15:0] cnt = '0;
  logic [47:0] cmp = '0;
  logic [7:0]  dead = '0;
  logic        we = 1'b0;
  logic [11:0] wdata = '0;
  logic [5:0]  pwm;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbpwm_3ph u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .cnt_i       (cnt),
    .cmp_i       (cmp),
    .dead_i      (dead),
    .act_we_i    (we),
    .act_wdata_i (wdata),
    .pwm_o       (pwm)
  );

  typedef struct packed {
    logic [15:0] cnt;
    logic [47:0] cmp;
    logic [5:0]  exp;
  } vec_t;

  // default codes: each pair reads ~raw on both pins (R1, R9)
  localparam vec_t VECS [0:4] = '{
    '{16'd100,   {16'd100,   16'd50,  16'd200},   6'b111100},
    '{16'd0,     {16'hFFFF,  16'd0,   16'd1},     6'b001100},
    '{16'hFFFF,  {16'd1000,  16'd0,   16'hFFFF},  6'b111111},
    '{16'd500,   {16'd501,   16'd501, 16'd501},   6'b000000},
    '{16'd499,   {16'd498,   16'd500, 16'd499},   6'b110011}
  };

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle_ph0(int d);
    dead = d[7:0];
    cnt = 16'd100;
    cmp = {16'd50, 16'd50, 16'd50};
    repeat (260) step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset pins", pwm, 6'b010101);
    rst_n = 1'b1;
    step();

    // table walk (R1, R9)
    for (int i = 0; i < 5; i++) begin
      cnt = VECS[i].cnt;
      cmp = VECS[i].cmp;
      step();
      step();
      chk("R1/R9 table", pwm, VECS[i].exp);
    end

    // R2: D=3 edge timing on phase 0
    settle_ph0(3);
    chk("R2 pre-edge", pwm, 6'b111111);
    cmp[15:0] = 16'd200;
    for (int j = 1; j <= 6; j++) begin
      step();
      chk("R2 dead=3", {4'b1111, pwm[1:0]},
          {4'b1111, (j < 2) ? 2'b11 : ((j < 5) ? 2'b01 : 2'b00)});
    end

    // R3: D=0, both change together
    settle_ph0(0);
    cmp[15:0] = 16'd200;
    for (int j = 1; j <= 3; j++) begin
      step();
      chk("R3 dead=0", {4'b1111, pwm[1:0]},
          {4'b1111, (j < 2) ? 2'b11 : 2'b00});
    end

    // R3: D=255 boundary
    settle_ph0(255);
    cmp[15:0] = 16'd200;
    for (int j = 1; j <= 258; j++) begin
      step();
      if (j == 1 || j == 2 || j == 256 || j == 257 || j == 258)
        chk("R3 dead=255", {4'b1111, pwm[1:0]},
            {4'b1111, (j < 2) ? 2'b11 : ((j < 257) ? 2'b01 : 2'b00)});
    end

    // R4: 3-clock pulse under D=5
    settle_ph0(5);
    cmp[15:0] = 16'd200;
    for (int j = 1; j <= 12; j++) begin
      step();
      chk("R4 short pulse", {4'b1111, pwm[1:0]},
          {4'b1111, (j < 2 || j >= 10) ? 2'b11 : 2'b01});
      if (j == 3) cmp[15:0] = 16'd50;
    end

    // R5/R6: shadow write mid-period, load at zero
    dead = 8'd0;
    cnt = 16'd100;
    cmp = {16'd200, 16'd50, 16'd200};
    repeat (3) step();
    chk("R1 before codes", pwm, 6'b001100);
    wdata = 12'h663;
    we = 1'b1;
    step();
    we = 1'b0;
    repeat (3) step();
    chk("R6 shadow held", pwm, 6'b001100);
    cnt = 16'd0;
    step();
    cnt = 16'd100;
    repeat (3) step();
    chk("R5 new codes", pwm, 6'b110001);

    // R8: disable parks pins
    en = 1'b0;
    step();
    chk("R8 disabled", pwm, 6'b101000);
    step();
    chk("R8 disabled hold", pwm, 6'b101000);
    en = 1'b1;
    step();
    chk("R8 re-enabled", pwm, 6'b110001);

    // restore defaults through shadow
    wdata = 12'h999;
    we = 1'b1;
    step();
    we = 1'b0;
    cnt = 16'd0;
    step();
    cnt = 16'd100;
    repeat (3) step();
    chk("R6 default reload", pwm, 6'b001100);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule